// File: doc/BRIEF.md
# Four-Pin Bidirectional GPIO Port Registers

This block is the register side of a four-pin general-purpose I/O port in a small microcontroller. Software reaches it over an 8-bit register bus. It holds a direction register and an output data register, and it offers a read-only port status view. Per-pin output values and output enables go to the pad buffers. Pin inputs come back through a two-stage synchronizer. On a status read, each pin set as an output returns its data latch bit, and each pin set as an input returns its synchronized pin level.

A small power-mode state machine follows two standby inputs. Its states are `MODE_RUN` (normal operation), `MODE_SOFT` (software standby) and `MODE_HARD` (hardware standby). The transitions are:
- RUN→HARD and SOFT→HARD when `hw_stby` rises.
- RUN→SOFT when `sw_stby` is high and `hw_stby` is low.
- SOFT→RUN when `sw_stby` falls.
- HARD→RUN, or HARD→SOFT, when `hw_stby` falls, chosen by `sw_stby`.

In HARD the registers are cleared, as on reset. In SOFT they are kept and the synchronizer is frozen. Writes are accepted only in RUN. Reads are served in every state.

Top module: `gpio4_port`

## Requirements
- R1: After reset (`rst_n` low), the direction register, the data register and `bus_rdata` are 0, so `pin_oe` and `pin_out` are 0.
- R2: A RUN-state write to address 0 (direction) stores bits 3:0. `pin_oe[i]` is 1 exactly when direction bit i is 1, from the cycle after the write.
- R3: A RUN-state write to address 1 (data) stores bits 3:0. `pin_out` equals the data register, and reading address 1 returns it.
- R4: Bits 7:4 of any write are ignored, and bits 7:4 of `bus_rdata` always read as 0.
- R5: Reading address 2 (status) returns, for each bit i, the data register bit when direction bit i is 1, and the synchronized pin level when it is 0.
- R6: A pin change seen on `pin_in` before clock edge E is visible to a status read whose strobe is sampled at edge E+2, but not at edge E+1.
- R7: A write to address 2 changes neither the direction register nor the data register.
- R8: While `hw_stby` is high, the state is HARD from the next edge. The registers are cleared at the edge after that, and writes are ignored.
- R9: While in SOFT, writes are ignored, `pin_out` and `pin_oe` hold, and status reads return the pin levels sampled before SOFT was entered.
- R10: `bus_rdata` is registered. It takes the addressed value at the edge where `bus_rd` is sampled high and holds otherwise.
- R11: Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby request (clears state) |
| sw_stby | input | 1 | Software standby request (keeps state) |
| bus_addr | input | 2 | Register address: 0 direction, 1 data, 2 status, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Output values to the pads |
| pin_oe | output | 4 | Per-pin output enables |

## Verification
The assertions assume the following about the inputs:
- `bus_wr` and `bus_rd` are single-cycle strobes driven with a stable `bus_addr` and `bus_wdata`.
- The standby inputs change only between accesses.
- A pin level stays put long enough to pass through the synchronizer before it is expected in a read.

The stimulus keeps to these assumptions. It drives every input at the falling edge. It lets three cycles pass after a pin change before a status read is checked, except in the latency test, which reads on purpose one cycle early. It raises a standby input one cycle before trying the accesses it is expected to block.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_HARD = 2'd2
    } mode_e;

    localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hw_stby,
    input  logic  sw_stby,
    output mode_e mode,
    output logic  wr_allow,
    output logic  clr,
    output logic  sync_en
);
    mode_e mode_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_nxt;
    end

    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MODE_RUN: begin
                if (hw_stby)      mode_nxt = MODE_HARD;
                else if (sw_stby) mode_nxt = MODE_SOFT;
            end
            MODE_SOFT: begin
                if (hw_stby)       mode_nxt = MODE_HARD;
                else if (!sw_stby) mode_nxt = MODE_RUN;
            end
            MODE_HARD: begin
                if (!hw_stby) mode_nxt = sw_stby ? MODE_SOFT : MODE_RUN;
            end
            default: mode_nxt = MODE_RUN;
        endcase
    end

    always_comb begin
        wr_allow = 1'b0;
        clr      = 1'b0;
        sync_en  = 1'b1;
        unique case (mode)
            MODE_RUN:  wr_allow = 1'b1;
            MODE_SOFT: sync_en  = 1'b0;
            MODE_HARD: clr      = 1'b1;
            default:   clr      = 1'b1;
        endcase
    end

    // R8: hardware standby takes over at the next edge
    p_hard_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (mode == MODE_HARD));
    // R9: software standby is left only on its falling request
    p_soft_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOFT && sw_stby && !hw_stby) |=> (mode == MODE_SOFT));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stg[s] <= '0;
                else if (en) stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stg[s] <= '0;
                else if (en) stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

    // R9: frozen synchronizer keeps its output
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_allow,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     wdata,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  data,
    output logic [DW-1:0]     rdata
);
    localparam int PADW = DW - NPINS;

    logic [NPINS-1:0] status;
    logic [DW-1:0]    rd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir  <= '0;
            data <= '0;
        end else if (clr) begin
            dir  <= '0;
            data <= '0;
        end else if (wr && wr_allow) begin
            if (addr == ADDR_DIR)  dir  <= wdata[NPINS-1:0];
            if (addr == ADDR_DATA) data <= wdata[NPINS-1:0];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        assign status[i] = dir[i] ? data[i] : pin_sync[i];
    end

    always_comb begin
        unique case (addr)
            ADDR_DIR:  rd_word = {{PADW{1'b0}}, dir};
            ADDR_DATA: rd_word = {{PADW{1'b0}}, data};
            ADDR_STAT: rd_word = {{PADW{1'b0}}, status};
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_word;
    end

    // R8: registers are empty after a clearing cycle
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dir == '0 && data == '0));
    // R3: accepted data write lands in the latch
    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_allow && !clr && addr == ADDR_DATA) |=> (data == $past(wdata[NPINS-1:0])));
    // R7: status address is not writable
    p_stat_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && addr == ADDR_STAT) |=> ($stable(dir) && $stable(data)));
    // R10: read data holds without a strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    // R4: reserved read bits are zero
    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NPINS] == '0);
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    mode_e            mode;
    logic             wr_allow;
    logic             clr;
    logic             sync_en;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] data_q;

    gpio_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_stby  (hw_stby),
        .sw_stby  (sw_stby),
        .mode     (mode),
        .wr_allow (wr_allow),
        .clr      (clr),
        .sync_en  (sync_en)
    );

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sync_en),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_allow (wr_allow),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .dir      (dir_q),
        .data     (data_q),
        .rdata    (bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = data_q;

    // R9: pad controls hold through software standby
    p_soft_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOFT) |=> ($stable(pin_out) && $stable(pin_oe)));
    // R2: direction write reaches the enables
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode == MODE_RUN && bus_addr == ADDR_DIR) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));
endmodule

// File: tb/gpio4_port_tb.sv
module gpio4_port_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [3:0] m_dir = '0;
    logic [3:0] m_data = '0;
    logic [3:0] m_pins = '0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio4_port u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_status(logic [3:0] d, logic [3:0] q, logic [3:0] p);
        return {4'h0, (d & q) | (~d & p)};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {4'h0, pin_oe}, 8'h00);
        check("R1 out", {4'h0, pin_out}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        do_read(2'd0, rv); check("R1 dir", rv, 8'h00);
        do_read(2'd1, rv); check("R1 data", rv, 8'h00);

        // R2 and R4 direction write with reserved bits set
        do_write(2'd0, 8'hA5); m_dir = 4'h5;
        check("R2 oe", {4'h0, pin_oe}, 8'h05);
        do_read(2'd0, rv); check("R4 dir readback", rv, 8'h05);

        // R3 data write
        do_write(2'd1, 8'hFC); m_data = 4'hC;
        check("R3 out", {4'h0, pin_out}, 8'h0C);
        do_read(2'd1, rv); check("R3 data readback", rv, 8'h0C);

        // R5 mixed status
        pin_in = 4'hA; m_pins = 4'hA;
        repeat (3) @(negedge clk);
        do_read(2'd2, rv); check("R5 status", rv, exp_status(m_dir, m_data, m_pins));

        // R6 latency with all pins inputs
        do_write(2'd0, 8'h00); m_dir = 4'h0;
        pin_in = 4'h0;
        repeat (3) @(negedge clk);
        pin_in = 4'hF;
        @(negedge clk);
        do_read(2'd2, rv); check("R6 early read", rv, 8'h00);
        do_read(2'd2, rv); check("R6 settled read", rv, 8'h0F);
        m_pins = 4'hF;

        // R7 write to status ignored
        do_write(2'd0, 8'h06); m_dir = 4'h6;
        do_write(2'd2, 8'hFF);
        check("R7 oe", {4'h0, pin_oe}, {4'h0, m_dir});
        check("R7 out", {4'h0, pin_out}, {4'h0, m_data});
        do_read(2'd1, rv); check("R7 data", rv, {4'h0, m_data});

        // R10 read data holds without strobe
        do_read(2'd1, rv);
        pin_in = 4'h3; m_pins = 4'h3;
        do_write(2'd1, 8'h05); m_data = 4'h5;
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, 8'h0C);

        // R11 unused address
        do_read(2'd3, rv); check("R11 unused", rv, 8'h00);

        // R9 software standby
        do_write(2'd0, 8'h03); m_dir = 4'h3;
        do_write(2'd1, 8'h03); m_data = 4'h3;
        pin_in = 4'h0; m_pins = 4'h0;
        repeat (3) @(negedge clk);
        sw_stby = 1'b1;
        @(negedge clk);
        do_write(2'd1, 8'h00);
        do_write(2'd0, 8'h00);
        pin_in = 4'hF;
        repeat (3) @(negedge clk);
        check("R9 out held", {4'h0, pin_out}, 8'h03);
        check("R9 oe held", {4'h0, pin_oe}, 8'h03);
        do_read(2'd2, rv); check("R9 status frozen", rv, 8'h03);
        sw_stby = 1'b0; m_pins = 4'hF;
        repeat (4) @(negedge clk);
        do_read(2'd2, rv); check("R9 status resumed", rv, exp_status(m_dir, m_data, m_pins));

        // R8 hardware standby
        do_write(2'd0, 8'h0F); do_write(2'd1, 8'h09);
        hw_stby = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 oe cleared", {4'h0, pin_oe}, 8'h00);
        check("R8 out cleared", {4'h0, pin_out}, 8'h00);
        do_write(2'd0, 8'h0F);
        check("R8 write ignored", {4'h0, pin_oe}, 8'h00);
        hw_stby = 1'b0;
        @(negedge clk);
        m_dir = 4'h0; m_data = 4'h0;
        do_read(2'd0, rv); check("R8 dir", rv, 8'h00);
        do_read(2'd1, rv); check("R8 data", rv, 8'h00);

        // random phase: R2 R3 R5 R7
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [7:0] v;
            op = $urandom % 4;
            v = 8'($urandom);
            case (op)
                0: begin do_write(2'd0, v); m_dir = v[3:0]; end
                1: begin do_write(2'd1, v); m_data = v[3:0]; end
                2: do_write(2'd2, v);
                default: begin
                    pin_in = v[3:0]; m_pins = v[3:0];
                    repeat (3) @(negedge clk);
                end
            endcase
            check("R2 rand oe", {4'h0, pin_oe}, {4'h0, m_dir});
            check("R3 rand out", {4'h0, pin_out}, {4'h0, m_data});
            if (op == 3) begin
                do_read(2'd2, rv);
                check("R5 rand status", rv, exp_status(m_dir, m_data, m_pins));
            end
        end
        report();
    end
endmodule